// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and delivers the 8-bit product after a fixed run of clock cycles. It uses one 4-bit ripple-carry adder, built from paired half adders, and two 4-bit right-shift registers. The upper register is the accumulator and the lower one holds the multiplier. A single carry flip-flop keeps the adder's carry-out until the next shift.

A pulse on `start` while the block is idle does three things. It captures the multiplicand, clears the accumulator and carry, and loads the multiplier register. The controller then runs four iterations of two steps each. In the first step, if the low bit of the multiplier register is 1, the accumulator takes the sum and the carry flip-flop takes the carry-out. In the second step, the carry, the accumulator and the multiplier register shift right together as one 9-bit chain. After the last shift, `done` pulses and the product stays on the output until the next accepted start.

Top module: `mul_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `product` is 0, `busy` is 0 and `done` is 0.
- R2: When `start` is 1 at a clock edge and `busy` is 0, the block accepts it. `busy` reads 1 after that edge, and `mcand` and `mplier` are captured at that edge.
- R3: `done` is 1 for exactly one cycle, after the 8th clock edge that follows the accepting edge. In that cycle `busy` is 0. `busy` stays 1 from the accepting edge until that 8th edge.
- R4: In the cycle where `done` is 1, `product` equals the unsigned product of the captured operands. This holds for every one of the 256 operand pairs.
- R5: While `busy` is 1, `start` and any change on `mcand` or `mplier` have no effect on the result or on its timing.
- R6: While `busy` is 0 and no start is accepted, `product` holds its value regardless of the operand inputs.
- R7: A `start` applied in the cycle where `done` is 1 is accepted, and that run completes with its own correct product.
- R8: When an add step's 4-bit sum overflows, the carry-out enters the top bit of the accumulator on the following shift. For example, 15×15 gives 225 and 15×8 gives 120.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | 4 | Multiplicand operand |
| mplier | input | 4 | Multiplier operand |
| product | output | 8 | Accumulator (high nibble) joined to multiplier register (low nibble) |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The `done` pulse of one run and the acceptance of the next `start` can fall in the same cycle. The bench provokes this by raising `start` with fresh operands exactly when it sees `done`. It then judges that the second product arrives eight edges later and is correct, and that the first product was already correct in the `done` cycle. A second overlap is a `start` raised while `busy` is 1, with the operands changed at the same time. That run must still finish on time with the original operands' product.

// File: rtl/mul_pkg.sv
`timescale 1ns/1ps
package mul_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADD   = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;
endpackage

// File: rtl/half_adder.sv
`timescale 1ns/1ps
module half_adder (
    input  logic a,
    input  logic b,
    output logic s,
    output logic c
);
    assign s = a ^ b;
    assign c = a & b;
endmodule

// File: rtl/ripple_adder.sv
`timescale 1ns/1ps
module ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    // each full adder: two half adders, carries joined by OR
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, c1, c2;
        half_adder u_ha0 (.a(x[i]), .b(y[i]),  .s(s1),     .c(c1));
        half_adder u_ha1 (.a(s1),   .b(cy[i]), .s(sum[i]), .c(c2));
        assign cy[i+1] = c1 | c2;
    end

    assign cout = cy[W];
endmodule

// File: rtl/shift_reg.sv
`timescale 1ns/1ps
module shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld_n,   // 0: parallel load, 1: shift right
    input  logic         si,
    input  logic [W-1:0] par,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (en) begin
            if (!ld_n) q_d = par;
            else       q_d = {si, q_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= '0;
        else     q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/mul_ctrl.sv
`timescale 1ns/1ps
module mul_ctrl #(
    parameter int ITERS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic go,
    output logic add_ph,
    output logic shift_ph,
    output logic busy,
    output logic done
);
    import mul_pkg::*;

    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (start) begin
                    c_d.ph  = PH_ADD;
                    c_d.cnt = '0;
                end
            end
            PH_ADD: c_d.ph = PH_SHIFT;
            PH_SHIFT: begin
                if (c_q.cnt == LAST) begin
                    c_d.ph   = PH_IDLE;
                    c_d.done = 1'b1;
                end else begin
                    c_d.ph  = PH_ADD;
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        else     c_q <= c_d;
    end

    assign go       = (c_q.ph == PH_IDLE) && start;
    assign add_ph   = (c_q.ph == PH_ADD);
    assign shift_ph = (c_q.ph == PH_SHIFT);
    assign busy     = (c_q.ph != PH_IDLE);
    assign done     = c_q.done;
endmodule

// File: rtl/mul_top.sv
`timescale 1ns/1ps
module mul_top #(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] product,
    output logic           busy,
    output logic           done
);
    typedef struct packed {
        logic         carry;
        logic [W-1:0] mc;
    } dp_t;

    dp_t d_d, d_q;

    logic         go, add_ph, shift_ph;
    logic [W-1:0] acc, mreg, sum;
    logic         cout, do_add;

    mul_ctrl #(.ITERS(W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .go(go), .add_ph(add_ph), .shift_ph(shift_ph),
        .busy(busy), .done(done)
    );

    ripple_adder #(.W(W)) u_add (
        .x(acc), .y(d_q.mc), .sum(sum), .cout(cout)
    );

    assign do_add = add_ph && mreg[0];

    // accumulator: cleared on go, loaded with sum on add, shifts in the carry
    shift_reg #(.W(W)) u_acc (
        .clk(clk), .rst(rst),
        .en(go || do_add || shift_ph),
        .ld_n(shift_ph),
        .si(d_q.carry),
        .par(go ? '0 : sum),
        .q(acc)
    );

    // multiplier register: loaded on go, receives accumulator low bit on shift
    shift_reg #(.W(W)) u_mreg (
        .clk(clk), .rst(rst),
        .en(go || shift_ph),
        .ld_n(shift_ph),
        .si(acc[0]),
        .par(mplier),
        .q(mreg)
    );

    always_comb begin
        d_d = d_q;
        if (go) begin
            d_d.carry = 1'b0;
            d_d.mc    = mcand;
        end else if (do_add) begin
            d_d.carry = cout;
        end else if (shift_ph) begin
            d_d.carry = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) d_q <= '0;
        else     d_q <= d_d;
    end

    assign product = {acc, mreg};
endmodule

// File: rtl/mul_chk.sv
`timescale 1ns/1ps
module mul_chk #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [W-1:0]   mcand,
    input logic [W-1:0]   mplier,
    input logic [2*W-1:0] product,
    input logic           busy,
    input logic           done
);
    logic [2*W-1:0] exp_q;
    logic [7:0]     lat_q;
    logic           accept;

    assign accept = !busy && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            lat_q <= '0;
        end else if (accept) begin
            exp_q <= (2*W)'(mcand) * (2*W)'(mplier);
            lat_q <= '0;
        end else if (busy) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // counter window, also checks R5: starts while busy do not restart the run
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == 8'(2*W)));

    assert_product_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == exp_q));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind mul_top mul_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .product(product), .busy(busy), .done(done)
);

// File: tb/mul_top_test.sv
`timescale 1ns/1ps
module mul_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] mcand = '0;
    logic [3:0] mplier = '0;
    logic [7:0] product;
    logic       busy, done;

    int total = 0;
    int bad = 0;

    mul_top #(.W(4)) uut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .product(product), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge: raise start with operands for the coming edge
    task automatic launch(input int a, input int b);
        start  = 1'b1;
        mcand  = 4'(a);
        mplier = 4'(b);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
    endtask

    // from negedge after accepting edge; ends at negedge where done is seen
    task automatic finish(input int a, input int b, input bit noise);
        for (int i = 1; i < 8; i++) begin
            @(negedge clk);
            if (noise && i == 3) begin
                start  = 1'b1;
                mcand  = ~4'(a);
                mplier = ~4'(b);
            end
            if (noise && i == 5) start = 1'b0;
            if (done) check(1'b0, "R3 early done", i, 8);
            if (!busy) check(1'b0, "R3 busy dropped early", i, 8);
        end
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, noise ? "R5 done timing" : "R3 done pulse", int'(done), 1);
        check(busy == 1'b0, "R3 idle at done", int'(busy), 0);
        check(product == 8'(a * b), noise ? "R5 product" : "R4 product",
              int'(product), a * b);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(product == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 in reset",
              int'(product), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(product == 8'd0 && busy == 1'b0 && done == 1'b0, "R1 after reset",
              int'({busy, done}), 0);

        // R4 exhaustive sweep, includes 0, 1, R8 cases 15x15 and 15x8
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                launch(a, b);
                finish(a, b, 1'b0);
                @(negedge clk);
                check(done == 1'b0, "R3 done one cycle", int'(done), 0);
            end
        end

        // R8 explicit carry cases
        launch(15, 15);
        finish(15, 15, 1'b0);
        check(product == 8'd225, "R8 15x15", int'(product), 225);
        @(negedge clk);
        launch(15, 8);
        finish(15, 8, 1'b0);
        check(product == 8'd120, "R8 15x8", int'(product), 120);

        // R6 hold while idle with changing inputs
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            mcand  = 4'(k + 3);
            mplier = 4'(k * 5);
            check(product == 8'd120, "R6 hold idle", int'(product), 120);
        end

        // R5 start and operand changes while busy
        @(negedge clk);
        launch(11, 13);
        finish(11, 13, 1'b1);
        @(negedge clk);
        launch(6, 9);
        finish(6, 9, 1'b1);

        // R7 start in the done cycle
        @(negedge clk);
        launch(7, 5);
        finish(7, 5, 1'b0);
        launch(14, 3);
        finish(14, 3, 1'b0);
        check(product == 8'd42, "R7 chained product", int'(product), 42);
        launch(0, 15);
        finish(0, 15, 1'b0);
        launch(12, 12);
        finish(12, 12, 1'b0);
        check(product == 8'd144, "R7 second chain", int'(product), 144);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7 idle after chain", int'({busy, done}), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule